// File: doc/BRIEF.md
# Byte-Parallel CRC-8 Accumulator

This block keeps a running 8-bit cyclic redundancy checksum over a stream of bytes and takes a whole byte on every cycle in which the byte strobe is high. Its state is an 8-bit register that holds the remainder, so far, of the modulo-2 division of the message by the generator x^8 + x^2 + x + 1 (0x07). The register starts at 00h. The block does no bit reflection and applies no final inversion.

Each accepted byte is absorbed in one cycle, with no bit-by-bit shifting. A per-bit selector combines the current remainder with the incoming byte to form an 8-bit index. A constant 256-entry remainder table, computed at elaboration, maps that index to the next remainder. To use the block, clear it, stream the message, and read the remainder as the checksum. A receiver streams the message followed by its checksum byte and expects 00h.

Top module: `crc8_byte_accum`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the remainder becomes 00h, and it is 00h on the first cycle after reset is released.
- R2: A byte presented with `in_valid` high and `clr` low is absorbed at that edge. From the next cycle, `crc_out` equals the CRC of all bytes since the last clear or reset. The CRC uses generator 0x07 and starts at 00h. Each byte is processed most significant bit first, with no reflection and no final XOR.
- R3: In a cycle with `in_valid` and `clr` both low, the remainder does not change.
- R4: `clr` high forces the remainder to 00h on the next cycle, and it overrides a byte presented in the same cycle.
- R5: For the byte sequence 11h, AAh, ACh, DAh, 59h, A8h, 9Ch, EFh, given in that order after a clear, `crc_out` equals the bit-serial CRC-8 (0x07) of that sequence.
- R6: Appending the obtained checksum as a further byte after the same sequence leaves the remainder at 00h. The next remainder is 00h exactly when the absorbed byte equals the current remainder.
- R7: Starting from 00h, absorbing a 00h byte leaves 00h. Absorbing 01h gives 07h, the generator's low byte.
- R8: After a clear, a new message's checksum does not depend on any earlier message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Forces remainder to 00h; wins over `in_valid` |
| in_valid | input | 1 | Byte strobe; `in_data` is absorbed when high |
| in_data | input | 8 | Message byte |
| crc_out | output | 8 | Registered running remainder |

## Verification
A wrong table entry or a wrong selector bit changes `crc_out` on the cycle right after the affected byte. Every later remainder then differs from the bit-serial model until the next clear, so the fault surfaces within one cycle and is not masked. A remainder that leaks across a clear or drifts during idle cycles shows up at the next comparison. Such a fault also breaks the zero residue when the checksum byte is appended.

// File: rtl/crc8_pkg.sv
// Package: shared width and the constant remainder function of the CRC-8
// accumulator. Assumes a generator of degree CRC_W given by its low CRC_W bits.
package crc8_pkg;

    localparam int unsigned CRC_W    = 8;
    localparam logic [CRC_W-1:0] GEN_LOW = 8'h07;

    typedef logic [CRC_W-1:0] crc_t;

    // Remainder of (v * x^CRC_W) modulo the generator; used only on constants.
    function automatic crc_t rem_of(crc_t v, crc_t gen_low);
        crc_t r;
        r = v;
        for (int k = 0; k < CRC_W; k++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ gen_low) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc8_index_sel.sv
// Module: per-bit selector forming the table index from the remainder and the
// incoming byte. Each index bit takes the data bit or its inverse, chosen by
// the matching remainder bit. Purely combinational.
module crc8_index_sel #(
    parameter int unsigned W = crc8_pkg::CRC_W
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] data,
    output logic [W-1:0] idx
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        // One-bit selector: inverted data bit where the remainder bit is set.
        assign idx[b] = acc[b] ? ~data[b] : data[b];
    end

endmodule

// File: rtl/crc8_rem_table.sv
// Module: constant lookup of the next remainder for a given index. The table
// is computed at elaboration from the generator; assumes W small enough for
// a 2^W-entry table.
module crc8_rem_table #(
    parameter int unsigned W       = crc8_pkg::CRC_W,
    parameter logic [W-1:0] GEN_LOW = crc8_pkg::GEN_LOW
) (
    input  logic [W-1:0] idx,
    output logic [W-1:0] rem
);

    localparam int unsigned DEPTH = 1 << W;

    logic [W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One constant entry: remainder of g * x^W.
        assign tbl[g] = crc8_pkg::rem_of(W'(g), GEN_LOW);
    end

    // Table read addressed by the combined index.
    assign rem = tbl[idx];

    // Entry 1 must equal the generator's low byte (R7).
    always_comb begin
        assert (tbl[1] == GEN_LOW) else $error("table entry 1 wrong (R7)");
    end

endmodule

// File: rtl/crc8_acc_reg.sv
// Module: the remainder register. Reset and clear load zero; a load writes
// the next remainder; otherwise it holds. Assumes clr outranks load.
module crc8_acc_reg #(
    parameter int unsigned W = crc8_pkg::CRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] acc
);

    // Remainder update with reset, clear-over-load priority and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (load) acc <= nxt;
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> acc == '0)
        else $error("remainder not zero after reset (R1)");

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(acc))
        else $error("remainder moved while idle (R3)");

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc == '0)
        else $error("clear did not zero remainder (R4)");

endmodule

// File: rtl/crc8_byte_accum.sv
// Module: top of the byte-parallel CRC-8 accumulator. One byte per valid
// cycle goes through the selector and the remainder table into the register;
// crc_out is the registered remainder. Assumes synchronous active-low reset.
module crc8_byte_accum #(
    parameter int unsigned W       = crc8_pkg::CRC_W,
    parameter logic [W-1:0] GEN_LOW = crc8_pkg::GEN_LOW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] crc_out
);

    logic [W-1:0] acc_q;
    logic [W-1:0] tbl_idx;
    logic [W-1:0] rem_nxt;

    crc8_index_sel #(.W(W)) sel_i (
        .acc  (acc_q),
        .data (in_data),
        .idx  (tbl_idx)
    );

    crc8_rem_table #(.W(W), .GEN_LOW(GEN_LOW)) tbl_i (
        .idx (tbl_idx),
        .rem (rem_nxt)
    );

    crc8_acc_reg #(.W(W)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (in_valid),
        .nxt   (rem_nxt),
        .acc   (acc_q)
    );

    // Output is the register itself.
    assign crc_out = acc_q;

    p_zero_residue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> ((crc_out == '0) == ($past(crc_out) == $past(in_data))))
        else $error("zero residue rule broken (R6)");

    p_zero_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && crc_out == '0 && in_data == '0) |=> crc_out == '0)
        else $error("zero byte from zero not zero (R7)");

endmodule

// File: tb/crc8_byte_accum_tb_top.sv
// Bench: scoreboard. The driver pushes the expected remainder per accepted
// byte or clear; the monitor pops and compares after the following edge.
module crc8_byte_accum_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] crc_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] model = 8'h00;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    crc8_byte_accum dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_data(in_data), .crc_out(crc_out)
    );

    // Bit-serial reference step, most significant bit first, generator 0x07.
    function automatic logic [7:0] serial_step(logic [7:0] c, logic [7:0] d);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs; push expectation when something is absorbed.
    task automatic drive(logic v, logic c, logic [7:0] d, string tag);
        @(negedge clk);
        in_valid = v; clr = c; in_data = d;
        if (c)      model = 8'h00;
        else if (v) model = serial_step(model, d);
        if (v || c) begin
            exp_q.push_back(model);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, "idle");
    endtask

    // Monitor: after each edge that absorbed a byte or clear, compare.
    always @(posedge clk) begin
        if (rst_n && (in_valid || clr)) begin
            #2;
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL scoreboard: got %02h expected nothing", crc_out);
            end else begin
                check(crc_out, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    logic [7:0] vec [8] = '{8'h11, 8'hAA, 8'hAC, 8'hDA, 8'h59, 8'hA8, 8'h9C, 8'hEF};
    logic [7:0] csum;
    logic [7:0] first_msg;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(crc_out, 8'h00, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        check(crc_out, 8'h00, "R1 after release");

        // R7: zero byte from zero, then 01h gives generator low byte.
        drive(1'b1, 1'b0, 8'h00, "R7 zero byte");
        drive(1'b1, 1'b0, 8'h01, "R7 byte 01h");
        idle(1);
        check(crc_out, 8'h07, "R7 01h gives 07h");

        // R5: test vector, back to back.
        drive(1'b0, 1'b1, 8'h00, "R4 clear");
        foreach (vec[i]) drive(1'b1, 1'b0, vec[i], "R5 vector step");
        idle(1);
        csum = model;
        check(crc_out, csum, "R5 vector checksum");

        // R3: idle cycles hold the remainder.
        idle(4);
        check(crc_out, csum, "R3 hold over idle");

        // R6: append checksum, expect zero residue.
        drive(1'b1, 1'b0, csum, "R6 append checksum");
        idle(1);
        check(crc_out, 8'h00, "R6 zero residue");

        // R2: varied patterns with gaps between bytes.
        drive(1'b0, 1'b1, 8'h00, "R4 clear");
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b0, 8'h01 << i, "R2 walking one");
            if (i % 3 == 0) idle(1);
        end
        drive(1'b1, 1'b0, 8'hFF, "R2 all ones");
        drive(1'b1, 1'b0, 8'h5A, "R2 pattern 5A");
        idle(2);
        check(crc_out, model, "R2 after gapped stream");

        // R4: clear together with a valid byte wins.
        drive(1'b1, 1'b1, 8'hC3, "R4 clear over valid");
        idle(1);
        check(crc_out, 8'h00, "R4 clear priority");

        // R8: second message independent of first.
        drive(1'b0, 1'b1, 8'h00, "R4 clear");
        drive(1'b1, 1'b0, 8'h3C, "R8 msg A");
        drive(1'b1, 1'b0, 8'h96, "R8 msg A");
        idle(1);
        first_msg = crc_out;
        drive(1'b1, 1'b0, 8'h77, "R8 filler");
        drive(1'b0, 1'b1, 8'h00, "R4 clear");
        drive(1'b1, 1'b0, 8'h3C, "R8 msg B");
        drive(1'b1, 1'b0, 8'h96, "R8 msg B");
        idle(1);
        check(crc_out, first_msg, "R8 repeat after clear");

        // R1: reset in mid-stream overrides a valid byte.
        drive(1'b1, 1'b0, 8'hA5, "R2 pre-reset byte");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_data = 8'h42;
        model = 8'h00;
        @(negedge clk);
        in_valid = 1'b0;
        check(crc_out, 8'h00, "R1 mid-run reset");
        rst_n = 1'b1;
        idle(2);
        check(crc_out, 8'h00, "R1 held after reset");

        idle(2);
        check(8'(exp_q.size()), 8'h00, "scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule